// File: doc/BRIEF.md
# External Interrupt Request Flag Register

This block holds one request flag for each external interrupt line. Each pin is active low and is first brought into the clock domain. A per-line sense-control bit selects how the flag is set: in low-level mode the flag is set while the pin is low, and in falling-edge mode it is set when the pin goes from high to low. Each flag drives its own request output towards the interrupt controller. The controller returns an acknowledge for the line when it takes the exception.

A flag clears in one of two ways. The first is the acknowledge. In falling-edge mode the acknowledge always clears the flag. In low-level mode it clears the flag only if the pin has already returned high. The second is a software write of 0 to the flag bit. Such a write only works if software read that flag as 1 beforehand. This guards against losing a request that arrived after the last read. Writing 1 to a flag has no effect. Reset and the standby condition both force the whole register to zero.

Top module: `irq_flag_reg`

## Requirements
- R1: While reset is asserted, and directly after it, the flag register, the read data and every request output are zero.
- R2: A cycle with standby high forces all flags to 0 on the next edge. It also discards any earlier read of a flag as 1, so a later write of 0 with no new read leaves a newly set flag at 1.
- R3: Register bits 7 and 6 always read as 0, and writing 1 to them changes nothing.
- R4: In low-level mode (sense bit 0), a flag is set while its synchronised pin is low. A clear attempted while the pin is still low does not leave the flag at 0.
- R5: In falling-edge mode (sense bit 1), a flag is set by a high-to-low transition of its synchronised pin. A pin that stays low does not set the flag again after it is cleared.
- R6: Writing 1 to a flag bit (bits 5..0 = lines 5..0) leaves that flag unchanged.
- R7: Writing 0 to a flag bit clears it only if a read strobe has returned that flag as 1 since the last write. Any write consumes the earlier read, so a second write of 0 does not clear.
- R8: In low-level mode, the acknowledge clears the flag only when the synchronised pin is high in that cycle.
- R9: In falling-edge mode, the acknowledge clears the flag whatever the pin level.
- R10: When a set condition and a clear condition (acknowledge or software write) fall in the same cycle, the flag ends at 1.
- R11: Each request output equals its flag bit. Read data equals the flag register during a read strobe and is 0 otherwise.
- R12: A pin change reaches the flag on the third rising clock edge after it is applied: two synchroniser stages plus the flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | Standby condition; clears the register |
| irq_n_i | input | 6 | External interrupt pins, active low, asynchronous |
| sense_edge_i | input | 6 | Per-line sense select: 0 low level, 1 falling edge |
| ack_i | input | 6 | Per-line exception-handling acknowledge |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data; bit n targets line n |
| rd_data_o | output | 8 | Read data, flag value before any same-cycle write |
| flags_o | output | 8 | Current flag register value |
| req_o | output | 6 | Per-line interrupt request |

## Verification
Two functions can fall in the same cycle: a new request being set and that flag being cleared. The clear can come from the acknowledge or from an armed software write of 0. The bench provokes this on purpose. It raises the acknowledge on exactly the cycle in which a falling edge reaches the detector. It also writes 0 to a flag whose pin is held low in level mode. Random traffic adds many more such collisions. Every cycle is judged against a reference model that follows the priority rule, and a collision must always leave the flag at 1.

// File: rtl/irqf_pkg.sv
package irqf_pkg;

   localparam int IRQF_LINES_DEF  = 6;
   localparam int IRQF_REG_W_DEF  = 8;
   localparam int IRQF_SYNC_DEF   = 2;

   typedef enum logic {
      SENSE_LOW_LEVEL = 1'b0,
      SENSE_FALL_EDGE = 1'b1
   } sense_mode_e;

endpackage

// File: rtl/irqf_sync.sv
module irqf_sync #(
   parameter int  WIDTH    = irqf_pkg::IRQF_LINES_DEF,
   parameter int  STAGES   = irqf_pkg::IRQF_SYNC_DEF,
   parameter bit  IDLE_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   localparam int CHAIN_W = WIDTH * STAGES;

   if (STAGES < 2) begin : g_bad_stages
      $error("irqf_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("irqf_sync: WIDTH must be at least 1");
   end

   logic [CHAIN_W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {CHAIN_W{IDLE_VAL}};
      end else begin
         chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], async_i};
      end
   end

   assign sync_o = chain_q[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/irqf_sense.sv
module irqf_sense
   import irqf_pkg::*;
#(
   parameter int NUM_LINES = IRQF_LINES_DEF
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] sync_i,
   input  logic [NUM_LINES-1:0] sense_edge_i,
   input  logic [NUM_LINES-1:0] ack_i,
   output logic [NUM_LINES-1:0] set_req_o,
   output logic [NUM_LINES-1:0] ack_clr_o
);

   logic [NUM_LINES-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '1;
      end else begin
         prev_q <= sync_i;
      end
   end

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
      sense_mode_e mode;
      logic        fall_seen;
      logic        low_seen;

      assign mode      = sense_mode_e'(sense_edge_i[n]);
      assign fall_seen = prev_q[n] & ~sync_i[n];
      assign low_seen  = ~sync_i[n];

      always_comb begin
         unique case (mode)
            SENSE_FALL_EDGE: begin
               set_req_o[n] = fall_seen;
               ack_clr_o[n] = ack_i[n];
            end
            default: begin
               set_req_o[n] = low_seen;
               ack_clr_o[n] = ack_i[n] & sync_i[n];
            end
         endcase
      end
   end

endmodule

// File: rtl/irqf_cell.sv
module irqf_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic standby_i,
   input  logic set_req_i,
   input  logic ack_clr_i,
   input  logic rd_en_i,
   input  logic wr_en_i,
   input  logic wr_bit_i,
   output logic flag_o
);

   logic flag_q;
   logic flag_d;
   logic armed_q;
   logic armed_d;
   logic sw_clr;

   always_comb begin
      sw_clr = wr_en_i & ~wr_bit_i & armed_q;

      if (standby_i) begin
         flag_d = 1'b0;
      end else if (set_req_i) begin
         flag_d = 1'b1;
      end else if (ack_clr_i | sw_clr) begin
         flag_d = 1'b0;
      end else begin
         flag_d = flag_q;
      end

      if (standby_i | wr_en_i | ~flag_d) begin
         armed_d = 1'b0;
      end else if (rd_en_i) begin
         armed_d = flag_q;
      end else begin
         armed_d = armed_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         flag_q  <= flag_d;
         armed_q <= armed_d;
      end
   end

   assign flag_o = flag_q;

   // R10
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_req_i && !standby_i) |=> flag_q);

   // R2
   standby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      standby_i |=> (!flag_q && !armed_q));

   // R6
   write_one_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && wr_en_i && wr_bit_i && !ack_clr_i && !standby_i) |=> flag_q);

   // R7
   unarmed_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && wr_en_i && !wr_bit_i && !armed_q && !ack_clr_i && !standby_i) |=> flag_q);

endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
   import irqf_pkg::*;
#(
   parameter int NUM_LINES   = IRQF_LINES_DEF,
   parameter int REG_W       = IRQF_REG_W_DEF,
   parameter int SYNC_STAGES = IRQF_SYNC_DEF
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 standby_i,
   input  logic [NUM_LINES-1:0] irq_n_i,
   input  logic [NUM_LINES-1:0] sense_edge_i,
   input  logic [NUM_LINES-1:0] ack_i,
   input  logic                 rd_en_i,
   input  logic                 wr_en_i,
   input  logic [REG_W-1:0]     wr_data_i,
   output logic [REG_W-1:0]     rd_data_o,
   output logic [REG_W-1:0]     flags_o,
   output logic [NUM_LINES-1:0] req_o
);

   localparam int RSV_W = REG_W - NUM_LINES;

   if (NUM_LINES < 1 || NUM_LINES > REG_W) begin : g_bad_lines
      $error("irq_flag_reg: NUM_LINES must be 1..REG_W");
   end

   logic [NUM_LINES-1:0] sync_q;
   logic [NUM_LINES-1:0] set_req;
   logic [NUM_LINES-1:0] ack_clr;
   logic [NUM_LINES-1:0] flag_vec;

   irqf_sync #(
      .WIDTH    (NUM_LINES),
      .STAGES   (SYNC_STAGES),
      .IDLE_VAL (1'b1)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (irq_n_i),
      .sync_o  (sync_q)
   );

   irqf_sense #(
      .NUM_LINES (NUM_LINES)
   ) u_sense (
      .clk          (clk),
      .rst_n        (rst_n),
      .sync_i       (sync_q),
      .sense_edge_i (sense_edge_i),
      .ack_i        (ack_i),
      .set_req_o    (set_req),
      .ack_clr_o    (ack_clr)
   );

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_cell
      irqf_cell u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .standby_i (standby_i),
         .set_req_i (set_req[n]),
         .ack_clr_i (ack_clr[n]),
         .rd_en_i   (rd_en_i),
         .wr_en_i   (wr_en_i),
         .wr_bit_i  (wr_data_i[n]),
         .flag_o    (flag_vec[n])
      );

      // R8
      level_ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_i[n] && !sense_edge_i[n] && !sync_q[n] && !standby_i) |=> flags_o[n]);

      // R5
      edge_fall_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($fell(sync_q[n]) && sense_edge_i[n] && !standby_i) |=> req_o[n]);
   end

   assign flags_o[NUM_LINES-1:0] = flag_vec;

   if (RSV_W > 0) begin : g_rsv
      logic unused_wr_rsv;
      assign flags_o[REG_W-1:NUM_LINES] = '0;
      assign unused_wr_rsv              = ^wr_data_i[REG_W-1:NUM_LINES];
   end

   assign req_o     = flag_vec;
   assign rd_data_o = rd_en_i ? flags_o : '0;

   // R11
   read_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |-> (rd_data_o == '0));

endmodule

// File: tb/irq_flag_reg_bench.sv
module irq_flag_reg_bench;

   localparam int NL = 6;
   localparam int RW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          standby = 1'b0;
   logic [NL-1:0] pin = '1;
   logic [NL-1:0] sense = '0;
   logic [NL-1:0] ack = '0;
   logic          rd = 1'b0;
   logic          wr = 1'b0;
   logic [RW-1:0] wd = '0;
   logic [RW-1:0] rdata;
   logic [RW-1:0] flags;
   logic [NL-1:0] req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   irq_flag_reg u_irq_flag_reg (
      .clk          (clk),
      .rst_n        (rst_n),
      .standby_i    (standby),
      .irq_n_i      (pin),
      .sense_edge_i (sense),
      .ack_i        (ack),
      .rd_en_i      (rd),
      .wr_en_i      (wr),
      .wr_data_i    (wd),
      .rd_data_o    (rdata),
      .flags_o      (flags),
      .req_o        (req)
   );

   // Reference model built from the requirements
   logic [NL-1:0] m_s1, m_s2, m_prev, m_flag, m_arm;

   always @(posedge clk) begin : ref_model
      logic [NL-1:0] nf;
      logic [NL-1:0] na;
      logic          st;
      logic          cl;
      if (!rst_n) begin
         m_s1 <= '1; m_s2 <= '1; m_prev <= '1; m_flag <= '0; m_arm <= '0;
      end else begin
         for (int n = 0; n < NL; n++) begin
            st = sense[n] ? (m_prev[n] && !m_s2[n]) : !m_s2[n];
            cl = (ack[n] && (sense[n] || m_s2[n])) || (wr && !wd[n] && m_arm[n]);
            if (standby)   nf[n] = 1'b0;
            else if (st)   nf[n] = 1'b1;
            else if (cl)   nf[n] = 1'b0;
            else           nf[n] = m_flag[n];
            if (standby || wr || !nf[n]) na[n] = 1'b0;
            else if (rd)                 na[n] = m_flag[n];
            else                         na[n] = m_arm[n];
         end
         m_s1 <= pin; m_s2 <= m_s1; m_prev <= m_s2;
         m_flag <= nf; m_arm <= na;
      end
   end

   task automatic chk(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      chk("R11 flags vs model", flags, RW'(m_flag));
      chk("R11 request outputs", RW'(req), RW'(m_flag));
      chk("R11 R3 read data", rdata, rd ? RW'(m_flag) : '0);
   endtask

   task automatic ticks(input int k);
      for (int i = 0; i < k; i++) tick();
   endtask

   task automatic do_rd();
      rd = 1'b1; tick(); rd = 1'b0;
   endtask

   task automatic do_wr(input logic [RW-1:0] d);
      wr = 1'b1; wd = d; tick(); wr = 1'b0;
   endtask

   task automatic do_ack(input int line);
      ack[line] = 1'b1; tick(); ack = '0;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      ticks(3);
      chk("R1 flags in reset", flags, 8'h00);
      rst_n = 1'b1;
      tick();
      chk("R1 flags after reset", flags, 8'h00);
      chk("R1 req after reset", RW'(req), 8'h00);

      // Level line 0, latency
      pin[0] = 1'b0;
      ticks(2);
      chk("R12 not yet after two edges", flags, 8'h00);
      tick();
      chk("R12 R4 set on third edge", flags, 8'h01);

      // Clear attempt while pin low: R4 and R10 (set wins)
      do_rd();
      do_wr(8'h00);
      chk("R4 R10 low pin beats write clear", flags, 8'h01);
      pin[0] = 1'b1;
      ticks(3);
      chk("R4 flag latched after pin high", flags, 8'h01);
      do_wr(8'h00);
      chk("R7 write 0 without read", flags, 8'h01);
      do_rd();
      do_wr(8'hFF);
      chk("R6 R3 write ones", flags, 8'h01);
      do_wr(8'h00);
      chk("R7 read consumed by earlier write", flags, 8'h01);
      do_rd();
      do_wr(8'h00);
      chk("R7 read then write 0 clears", flags, 8'h00);

      // R8 level acknowledge
      pin[0] = 1'b0;
      ticks(3);
      chk("R4 level set again", flags, 8'h01);
      do_ack(0);
      chk("R8 ack with low pin keeps flag", flags, 8'h01);
      pin[0] = 1'b1;
      ticks(3);
      do_ack(0);
      chk("R8 ack with high pin clears", flags, 8'h00);

      // R5 and R9 edge line 1
      sense[1] = 1'b1;
      tick();
      pin[1] = 1'b0;
      ticks(3);
      chk("R5 falling edge sets", flags, 8'h02);
      do_ack(1);
      chk("R9 edge ack clears while low", flags, 8'h00);
      ticks(3);
      chk("R5 steady low no retrigger", flags, 8'h00);
      pin[1] = 1'b1;
      ticks(3);
      chk("R5 rising edge no set", flags, 8'h00);
      pin[1] = 1'b0;
      ticks(3);
      chk("R5 second fall sets", flags, 8'h02);
      do_wr(8'hC0);
      chk("R3 reserved bits stay 0", flags, 8'h02);

      // R10 acknowledge in the same cycle as an edge set
      sense[2] = 1'b1;
      tick();
      pin[2] = 1'b0;
      ticks(2);
      ack[2] = 1'b1;
      tick();
      ack = '0;
      chk("R10 edge set beats ack", RW'(flags[2]), 8'h01);

      // R2 standby
      do_rd();
      standby = 1'b1;
      tick();
      standby = 1'b0;
      chk("R2 standby clears", flags, 8'h00);
      pin[2] = 1'b1;
      ticks(3);
      pin[2] = 1'b0;
      ticks(3);
      chk("R5 line 2 set after standby", RW'(flags[2]), 8'h01);
      do_wr(8'h00);
      chk("R2 read before standby discarded", RW'(flags[2]), 8'h01);

      // Random traffic
      for (int c = 0; c < 3000; c++) begin
         for (int n = 0; n < NL; n++) begin
            if ($urandom_range(0, 99) < 15) pin[n] = ~pin[n];
            if ($urandom_range(0, 99) < 2)  sense[n] = ~sense[n];
            ack[n] = ($urandom_range(0, 99) < 10);
         end
         rd = ($urandom_range(0, 99) < 30);
         wr = ($urandom_range(0, 99) < 20);
         wd = RW'($urandom());
         standby = ($urandom_range(0, 999) < 5);
         tick();
      end
      rd = 1'b0; wr = 1'b0; ack = '0; standby = 1'b0;

      // R1 reset in mid run
      rst_n = 1'b0;
      tick();
      chk("R1 reset mid run", flags, 8'h00);
      rst_n = 1'b1;
      tick();
      chk("R1 request after mid-run reset", RW'(req), 8'h00);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R1..all: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule